// File: doc/BRIEF.md
# Vector predicate mask generator

This block turns a compact predicate specification into a per-element enable mask for a vector operation. A one-bit mode input chooses between two sources. In integer mode the mask comes from one of three general-purpose register values supplied on the ports. Each value can be used as it is or bitwise inverted. The first value can also be turned into a single set bit whose position is given by its low six bits. An "all elements" selector gives a mask of all ones.

In condition mode the block is given a vector of 4-bit condition fields, one per element. For each element it picks one bit of that element's field, optionally inverts it, and places the result at the element's position in the mask. Only the first VL elements take part; every higher position reads zero.

The mask logic itself is combinational. A one-cycle request strobe captures its result into the output register. A two-state controller (`ST_IDLE`, `ST_FRESH`) raises a valid flag for exactly the cycle after each strobe. The transitions are:
- `IDLE->FRESH` on a strobe.
- `FRESH->FRESH` on a back-to-back strobe.
- `FRESH->IDLE` when no strobe arrives.

Top module: `vec_pred_mask`

## Requirements
- R1: After reset `mask_valid` is 0 and `mask_out` is all zeros.
- R2: A cycle with `req_valid` high loads the computed mask into `mask_out` and raises `mask_valid` for the following cycle only. In a cycle without `req_valid`, `mask_valid` is low in the next cycle and `mask_out` keeps its value.
- R3: In integer mode (`mode_cond`=0), `sel`=0 gives a mask of all ones.
- R4: In integer mode, `sel`=1 gives a single set bit at position `reg_a[5:0]`. Bits 63..6 of `reg_a` have no effect.
- R5: In integer mode, `sel` values 2 to 7 give `reg_a`, `~reg_a`, `reg_b`, `~reg_b`, `reg_c` and `~reg_c`, in that order.
- R6: In condition mode (`mode_cond`=1), element i uses field `cond_fields[4i+3:4i]`. Its mask bit is field bit `sel[2:1]`, inverted when `sel[0]`=1. So `sel` 0..7 test less-than, not-less-than, greater-than, not-greater-than, equal, not-equal, summary-overflow and not-summary-overflow (field bits 0,0,1,1,2,2,3,3).
- R7: In condition mode, mask bits at positions `vl` and above are 0. A `vl` of 64 or more enables all 64 elements, and `vl`=0 gives an all-zero mask.
- R8: In integer mode, `cond_fields` and `vl` have no effect on the mask. In condition mode, `reg_a`, `reg_b` and `reg_c` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Capture strobe for the computed mask |
| mode_cond | input | 1 | 0 = integer mode, 1 = condition mode |
| sel | input | 3 | Predicate selector |
| reg_a | input | 64 | First register value (also the unary source) |
| reg_b | input | 64 | Second register value |
| reg_c | input | 64 | Third register value |
| cond_fields | input | 256 | 64 four-bit condition fields, element i in bits 4i+3..4i |
| vl | input | 7 | Active vector length |
| mask_valid | output | 1 | High the cycle after a strobe |
| mask_out | output | 64 | Registered predicate mask |

## Verification
The bench builds the block with its defaults: a 64-element mask, 4-bit condition fields and a 7-bit length. With these values every unary shift position from 0 to 63 can be reached. So can every condition-field bit, and lengths that fall below, at and above the 64-element limit (0, 1, 63, 64 and up to 127). Random requests mix both modes with junk on the unused inputs, to show those inputs have no effect. Directed cases cover the edges of the length window, the top unary position, and back-to-back strobes.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

    localparam int unsigned MASK_W  = 64;
    localparam int unsigned FIELD_W = 4;

    // integer-mode selector codes
    typedef enum logic [2:0] {
        ISEL_ALL    = 3'd0,
        ISEL_UNARY  = 3'd1,
        ISEL_A      = 3'd2,
        ISEL_A_INV  = 3'd3,
        ISEL_B      = 3'd4,
        ISEL_B_INV  = 3'd5,
        ISEL_C      = 3'd6,
        ISEL_C_INV  = 3'd7
    } int_sel_e;

    // output controller states
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FRESH = 1'b1
    } pm_state_e;

endpackage

// File: rtl/pmask_int_gen.sv
module pmask_int_gen
    import pmask_pkg::*;
#(
    parameter int unsigned WIDTH = MASK_W
) (
    input  logic [2:0]       sel,
    input  logic [WIDTH-1:0] reg_a,
    input  logic [WIDTH-1:0] reg_b,
    input  logic [WIDTH-1:0] reg_c,
    output logic [WIDTH-1:0] mask
);
    localparam int unsigned SH_W = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    int_sel_e sel_e;
    logic [WIDTH-1:0] unary;

    assign sel_e = int_sel_e'(sel);
    assign unary = ONE << reg_a[SH_W-1:0];

    always_comb begin
        unique case (sel_e)
            ISEL_ALL:   mask = '1;
            ISEL_UNARY: mask = unary;
            ISEL_A:     mask = reg_a;
            ISEL_A_INV: mask = ~reg_a;
            ISEL_B:     mask = reg_b;
            ISEL_B_INV: mask = ~reg_b;
            ISEL_C:     mask = reg_c;
            ISEL_C_INV: mask = ~reg_c;
            default:    mask = '0;
        endcase
    end

    // R4: the unary form always has exactly one bit set
    always_comb begin
        if (sel_e == ISEL_UNARY) begin
            p_unary_single_r4: assert ($countones(unary) == 1 || $isunknown(reg_a))
                else $error("unary mask not one-hot");
        end
    end

endmodule

// File: rtl/pmask_cond_gen.sv
module pmask_cond_gen
    import pmask_pkg::*;
#(
    parameter int unsigned ELEMS = MASK_W,
    parameter int unsigned FLD_W = FIELD_W,
    parameter int unsigned LEN_W = $clog2(ELEMS + 1)
) (
    input  logic [2:0]             sel,
    input  logic [ELEMS*FLD_W-1:0] fields,
    input  logic [LEN_W-1:0]       vl,
    output logic [ELEMS-1:0]       mask
);
    localparam int unsigned BIT_W = $clog2(FLD_W);

    logic [BIT_W-1:0] bit_idx;
    logic             invert;

    assign bit_idx = sel[BIT_W:1];
    assign invert  = sel[0];

    for (genvar i = 0; i < ELEMS; i++) begin : g_elem
        localparam logic [LEN_W-1:0] POS = LEN_W'(i);
        logic [FLD_W-1:0] fld;
        logic             picked;
        logic             active;

        assign fld    = fields[i*FLD_W +: FLD_W];
        assign picked = fld[bit_idx] ^ invert;
        assign active = (vl > POS);
        assign mask[i] = picked & active;
    end

endmodule

// File: rtl/vec_pred_mask.sv
module vec_pred_mask
    import pmask_pkg::*;
#(
    parameter int unsigned ELEMS = MASK_W,
    parameter int unsigned FLD_W = FIELD_W,
    parameter int unsigned LEN_W = $clog2(ELEMS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   mode_cond,
    input  logic [2:0]             sel,
    input  logic [ELEMS-1:0]       reg_a,
    input  logic [ELEMS-1:0]       reg_b,
    input  logic [ELEMS-1:0]       reg_c,
    input  logic [ELEMS*FLD_W-1:0] cond_fields,
    input  logic [LEN_W-1:0]       vl,
    output logic                   mask_valid,
    output logic [ELEMS-1:0]       mask_out
);
    pm_state_e        state_q, state_d;
    logic [ELEMS-1:0] int_mask, cond_mask, mask_d, mask_q;

    pmask_int_gen #(.WIDTH(ELEMS)) u_int (
        .sel   (sel),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .reg_c (reg_c),
        .mask  (int_mask)
    );

    pmask_cond_gen #(.ELEMS(ELEMS), .FLD_W(FLD_W), .LEN_W(LEN_W)) u_cond (
        .sel    (sel),
        .fields (cond_fields),
        .vl     (vl),
        .mask   (cond_mask)
    );

    assign mask_d = mode_cond ? cond_mask : int_mask;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_FRESH;
            ST_FRESH: if (!req_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and mask capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) mask_q <= mask_d;
        end
    end

    // outputs
    always_comb begin
        mask_out   = mask_q;
        mask_valid = (state_q == ST_FRESH);
    end

    // R2: valid strictly one cycle after a strobe
    p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mask_valid);
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mask_valid);
    p_hold_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(mask_out));
    // R3: all-elements selector
    p_all_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_cond && sel == 3'd0) |=> (mask_out == '1));
    // R4: unary result is one-hot
    p_unary_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_cond && sel == 3'd1) |=> ($countones(mask_out) == 1));
    // R7: condition mode never enables more elements than the length
    p_cond_within_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_cond) |=> ($countones(mask_out) <= $past(vl)));

endmodule

// File: tb/test_vec_pred_mask.sv
module test_vec_pred_mask;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         mode_cond = 1'b0;
    logic [2:0]   sel = '0;
    logic [63:0]  reg_a = '0, reg_b = '0, reg_c = '0;
    logic [255:0] cond_fields = '0;
    logic [6:0]   vl = '0;
    logic         mask_valid;
    logic [63:0]  mask_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vec_pred_mask i_vec_pred_mask (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_cond(mode_cond),
        .sel(sel), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
        .cond_fields(cond_fields), .vl(vl),
        .mask_valid(mask_valid), .mask_out(mask_out)
    );

    function automatic logic [63:0] exp_mask(logic cm, logic [2:0] s, logic [63:0] a,
                                             logic [63:0] b, logic [63:0] c,
                                             logic [255:0] cf, logic [6:0] n);
        logic [63:0] r;
        r = '0;
        if (!cm) begin
            case (s)
                3'd0: r = '1;
                3'd1: r = 64'd1 << a[5:0];
                3'd2: r = a;
                3'd3: r = ~a;
                3'd4: r = b;
                3'd5: r = ~b;
                3'd6: r = c;
                default: r = ~c;
            endcase
        end else begin
            for (int i = 0; i < 64; i++)
                if (i < int'(n)) r[i] = cf[4*i + int'(s[2:1])] ^ s[0];
        end
        return r;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one strobed request and check the captured mask and its hold
    task automatic request(string req, logic cm, logic [2:0] s, logic [63:0] a,
                           logic [63:0] b, logic [63:0] c, logic [255:0] cf,
                           logic [6:0] n);
        logic [63:0] e;
        e = exp_mask(cm, s, a, b, c, cf, n);
        @(negedge clk);
        mode_cond = cm; sel = s; reg_a = a; reg_b = b; reg_c = c;
        cond_fields = cf; vl = n; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R2 valid"}, {63'd0, mask_valid}, 64'd1);
        check(req, mask_out, e);
        // scramble inputs: without a strobe nothing changes
        reg_a = rnd64(); cond_fields = {4{rnd64()}}; sel = 3'($urandom);
        @(negedge clk);
        check("R2 valid low", {63'd0, mask_valid}, 64'd0);
        check("R2 hold", mask_out, e);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] cf;
        logic [63:0]  e0, e1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 valid", {63'd0, mask_valid}, 64'd0);
        check("R1 mask", mask_out, 64'd0);
        rst_n = 1'b1;

        // directed integer cases
        request("R3", 1'b0, 3'd0, rnd64(), rnd64(), rnd64(), '0, 7'd0);
        request("R4 top", 1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, '0, 7'd0);
        request("R4 zero", 1'b0, 3'd1, 64'hABCD_0000_0000_0040, '0, '0, '0, 7'd5);
        for (int s = 2; s < 8; s++)
            request("R5", 1'b0, 3'(s), rnd64(), rnd64(), rnd64(), {4{rnd64()}}, 7'($urandom));
        // R8: length and fields ignored in integer mode
        request("R8 int", 1'b0, 3'd2, 64'h0123_4567_89AB_CDEF, '0, '0, '1, 7'd0);

        // directed condition cases
        cf = {4{rnd64()}};
        for (int s = 0; s < 8; s++)
            request("R6", 1'b1, 3'(s), '0, '0, '0, cf, 7'd64);
        request("R7 vl0", 1'b1, 3'd1, '0, '0, '0, '0, 7'd0);
        request("R7 vl1", 1'b1, 3'd1, '0, '0, '0, '0, 7'd1);
        request("R7 vl63", 1'b1, 3'd1, '0, '0, '0, '0, 7'd63);
        request("R7 vl127", 1'b1, 3'd1, '0, '0, '0, '0, 7'd127);
        request("R8 cond", 1'b1, 3'd4, '1, '1, '1, '0, 7'd64);

        // back-to-back strobes
        @(negedge clk);
        mode_cond = 1'b0; sel = 3'd2; reg_a = 64'h1111; req_valid = 1'b1;
        e0 = 64'h1111;
        @(negedge clk);
        check("R2 b2b first", mask_out, e0);
        sel = 3'd3; reg_a = 64'h2222;
        e1 = ~64'h2222;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 b2b valid", {63'd0, mask_valid}, 64'd1);
        check("R2 b2b second", mask_out, e1);
        @(negedge clk);
        check("R2 b2b idle", {63'd0, mask_valid}, 64'd0);

        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            logic cm;
            cm = 1'($urandom);
            request(cm ? "R6 R7 R8 rand" : "R3 R4 R5 R8 rand", cm, 3'($urandom),
                    rnd64(), rnd64(), rnd64(), {4{rnd64()}}, 7'($urandom));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule